// File: doc/BRIEF.md
# Per-Pin Aliased GPIO Register Bank

This block holds the output latches, output data masks and synchronized input levels for six GPIO ports of up to sixteen pins each. Software reaches it over a simple single-cycle register bus. Each port has three port-wide words: output, mask and input. Every pin also owns a private 32-bit word in an alias window. Writing a pin's alias word sets or clears that one output bit. Reading the same word returns the pin's synchronized input level in bit 0.

The alias path lets software drive a single pin without a read-modify-write sequence. It also ignores the data mask, so a masked pin can still be driven through its own word. The port-wide output write keeps masked bits at their old value. Ports 0 to 3 carry 16 pins, port 4 carries 14 pins and port 5 carries 8 pins. Missing pins stay low and read as zero.

Top module: `gpio_alias_bank`

## Requirements
- R1: Alias word for port p (0 to 5) and pin n sits at byte address 0x200 + 0x40*p + 4*n; address bits 1:0 are ignored for every access.
- R2: A read of an alias word returns the pin's synchronized input level in bit 0, and bits 31:1 are zero.
- R3: A write to an alias word copies write-data bit 0 into that pin's output latch bit (bit p*16+n of pin_o). The other output bits keep their values.
- R4: An alias write updates the output latch even when that pin's mask bit is 1.
- R5: A write to the port output word at 0x40*p+0x0 loads write data into the output bits whose mask bit is 0. Bits whose mask bit is 1 keep their old value. A read of this word returns the output latch.
- R6: Port 4 pins 14 and 15 and port 5 pins 8 to 15 are unimplemented. Their output bits stay 0, their alias words read 0, writes to them have no effect, and their bits read 0 in every port-wide word.
- R7: The mask word at 0x40*p+0x4 can be written and read back on implemented bits. The input word at 0x40*p+0x8 reads the port's synchronized pin levels in bits 15:0.
- R8: After reset, all output latches, masks and synchronizer stages are zero, and read data is zero.
- R9: Read data is registered. It holds the addressed value in the cycle after read enable, and zero after a cycle with read enable low. Unmapped addresses read zero: ports 6 and 7, word offsets 0xC to 0x3C of the port-wide region, and addresses at or above 0x400.
- R10: A pin level change becomes visible to a read whose enable is sampled at the third rising clock edge after the change, through a two-flop synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_addr_i | input | 12 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_we_i | input | 1 | Write enable |
| bus_re_i | input | 1 | Read enable |
| bus_rdata_o | output | 32 | Registered read data |
| pin_i | input | 96 | Pin input levels, port p pin n at bit p*16+n |
| pin_o | output | 96 | Output latch levels, same bit layout |

## Verification
The bench drives a masked pin through its alias word. A design that honoured the mask on that path would leave the pin unchanged. It writes and reads the missing pins of ports 4 and 5. A design that stored those bits would raise pin_o or return a 1. It issues alias accesses with nonzero low address bits, and unmapped reads just past port 5 and past the port-wide words. A wrong decoder would alias those addresses onto real registers. Random mixes of port writes, mask changes and pin changes test the masked merge. They also check that alias reads return the pin level and not the latch.

// File: rtl/gpio_alias_pkg.sv
package gpio_alias_pkg;
  localparam int unsigned NPORT_D = 6;
  localparam int unsigned PW_D    = 16;
  localparam logic [NPORT_D*PW_D-1:0] IMPL_D = 96'h00FF_3FFF_FFFF_FFFF_FFFF_FFFF;

  typedef enum logic [2:0] {
    ACC_NONE,
    ACC_OUT,
    ACC_MSK,
    ACC_IN,
    ACC_ALIAS
  } acc_e;
endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_alias_pkg::*;
#(
  parameter int unsigned NPORT = NPORT_D,
  parameter int unsigned AW    = 12
) (
  input  logic [AW-1:0] addr_i,
  output acc_e          kind_o,
  output logic [2:0]    port_o,
  output logic [3:0]    pin_o
);
  always_comb begin
    kind_o = ACC_NONE;
    port_o = addr_i[8:6];
    pin_o  = addr_i[5:2];
    if (addr_i[AW-1:10] == '0 && 32'(addr_i[8:6]) < NPORT) begin
      if (addr_i[9]) begin
        kind_o = ACC_ALIAS;
      end else begin
        case (addr_i[5:2])
          4'd0:    kind_o = ACC_OUT;
          4'd1:    kind_o = ACC_MSK;
          4'd2:    kind_o = ACC_IN;
          default: kind_o = ACC_NONE;
        endcase
      end
    end
  end
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
  parameter int unsigned   PW     = 16,
  parameter logic [PW-1:0] IMPL_P = '1,
  localparam int unsigned  PINB   = $clog2(PW)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            out_we_i,
  input  logic            msk_we_i,
  input  logic            alias_we_i,
  input  logic [PINB-1:0] pin_sel_i,
  input  logic [PW-1:0]   wdata_i,
  input  logic [PW-1:0]   pin_i,
  output logic [PW-1:0]   out_o,
  output logic [PW-1:0]   msk_o,
  output logic [PW-1:0]   in_o
);
  logic [PW-1:0] out_q, msk_q, sync1_q, sync2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= '0;
      msk_q <= '0;
    end else begin
      if (out_we_i)
        out_q <= ((out_q & msk_q) | (wdata_i & ~msk_q)) & IMPL_P;
      else if (alias_we_i && IMPL_P[pin_sel_i])
        out_q[pin_sel_i] <= wdata_i[0];  // mask deliberately bypassed
      if (msk_we_i)
        msk_q <= wdata_i & IMPL_P;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pin_i;
      sync2_q <= sync1_q;
    end
  end

  assign out_o = out_q;
  assign msk_o = msk_q;
  assign in_o  = sync2_q & IMPL_P;
endmodule

// File: rtl/gpio_alias_bank.sv
module gpio_alias_bank
  import gpio_alias_pkg::*;
#(
  parameter int unsigned            NPORT = NPORT_D,
  parameter int unsigned            PW    = PW_D,
  parameter int unsigned            AW    = 12,
  parameter int unsigned            DW    = 32,
  parameter logic [NPORT*PW-1:0]    IMPL  = IMPL_D,
  localparam int unsigned           NPIN  = NPORT * PW
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [AW-1:0]   bus_addr_i,
  input  logic [DW-1:0]   bus_wdata_i,
  input  logic            bus_we_i,
  input  logic            bus_re_i,
  output logic [DW-1:0]   bus_rdata_o,
  input  logic [NPIN-1:0] pin_i,
  output logic [NPIN-1:0] pin_o
);
  acc_e       kind;
  logic [2:0] port;
  logic [3:0] pin;

  gpio_addr_dec #(.NPORT(NPORT), .AW(AW)) u_dec (
    .addr_i (bus_addr_i),
    .kind_o (kind),
    .port_o (port),
    .pin_o  (pin)
  );

  logic [PW-1:0] out_a [NPORT];
  logic [PW-1:0] msk_a [NPORT];
  logic [PW-1:0] in_a  [NPORT];

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic sel;
    assign sel = bus_we_i && (32'(port) == p);

    gpio_port_regs #(.PW(PW), .IMPL_P(IMPL[p*PW +: PW])) u_regs (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .out_we_i   (sel && kind == ACC_OUT),
      .msk_we_i   (sel && kind == ACC_MSK),
      .alias_we_i (sel && kind == ACC_ALIAS),
      .pin_sel_i  (pin),
      .wdata_i    (bus_wdata_i[PW-1:0]),
      .pin_i      (pin_i[p*PW +: PW]),
      .out_o      (out_a[p]),
      .msk_o      (msk_a[p]),
      .in_o       (in_a[p])
    );

    assign pin_o[p*PW +: PW] = out_a[p];
  end

  logic [DW-1:0] rd_d;
  always_comb begin
    rd_d = '0;
    for (int p = 0; p < NPORT; p++) begin
      if (32'(port) == p) begin
        case (kind)
          ACC_OUT:   rd_d[PW-1:0] = out_a[p];
          ACC_MSK:   rd_d[PW-1:0] = msk_a[p];
          ACC_IN:    rd_d[PW-1:0] = in_a[p];
          ACC_ALIAS: rd_d[0]      = in_a[p][pin];
          default:   rd_d         = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bus_rdata_o <= '0;
    else         bus_rdata_o <= bus_re_i ? rd_d : '0;
  end
endmodule

// File: rtl/gpio_alias_bank_chk.sv
module gpio_alias_bank_chk #(
  parameter int unsigned         NPORT = 6,
  parameter int unsigned         PW    = 16,
  parameter int unsigned         AW    = 12,
  parameter int unsigned         DW    = 32,
  parameter logic [NPORT*PW-1:0] IMPL  = '1
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [AW-1:0]       bus_addr_i,
  input logic [DW-1:0]       bus_wdata_i,
  input logic                bus_we_i,
  input logic                bus_re_i,
  input logic [DW-1:0]       bus_rdata_o,
  input logic [NPORT*PW-1:0] pin_o
);
  logic       in_alias;
  logic [6:0] bit_idx;
  assign in_alias = bus_addr_i[AW-1:9] == 3'b001 && 32'(bus_addr_i[8:6]) < NPORT;
  assign bit_idx  = {bus_addr_i[8:6], bus_addr_i[5:2]};

  // R3 R4: alias write lands on its pin regardless of mask
  p_alias_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_we_i && in_alias && IMPL[bit_idx] |=> pin_o[$past(bit_idx)] == $past(bus_wdata_i[0]));

  p_alias_upper_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_re_i && in_alias |=> bus_rdata_o[DW-1:1] == '0);

  p_unimpl_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_o & ~IMPL) == '0);

  p_idle_rdata_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_re_i |=> bus_rdata_o == '0);

  p_no_write_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_we_i |=> $stable(pin_o));
endmodule

bind gpio_alias_bank gpio_alias_bank_chk #(
  .NPORT(NPORT), .PW(PW), .AW(AW), .DW(DW), .IMPL(IMPL)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .bus_we_i    (bus_we_i),
  .bus_re_i    (bus_re_i),
  .bus_rdata_o (bus_rdata_o),
  .pin_o       (pin_o)
);

// File: tb/gpio_alias_bank_tb.sv
module gpio_alias_bank_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic        bus_we_i = 1'b0;
  logic        bus_re_i = 1'b0;
  logic [31:0] bus_rdata_o;
  logic [95:0] pin_i = '0;
  logic [95:0] pin_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] out_m [6];
  logic [15:0] msk_m [6];

  always #4 clk_i = ~clk_i;

  gpio_alias_bank u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
    .bus_we_i(bus_we_i), .bus_re_i(bus_re_i), .bus_rdata_o(bus_rdata_o),
    .pin_i(pin_i), .pin_o(pin_o)
  );

  function automatic logic [15:0] impl(int p);
    return (p < 4) ? 16'hFFFF : (p == 4) ? 16'h3FFF : 16'h00FF;
  endfunction

  function automatic logic [95:0] exp_pins();
    logic [95:0] v = '0;
    for (int p = 0; p < 6; p++) v[p*16 +: 16] = out_m[p];
    return v;
  endfunction

  function automatic logic [11:0] alias_addr(int p, int n);
    return 12'(12'h200 + p * 64 + n * 4);
  endfunction

  task automatic chk(string req, logic [95:0] act, logic [95:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk_i);
    bus_addr_i = a; bus_wdata_i = d; bus_we_i = 1'b1;
    @(negedge clk_i);
    bus_we_i = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk_i);
    bus_addr_i = a; bus_re_i = 1'b1;
    @(negedge clk_i);
    d = bus_rdata_o;
    bus_re_i = 1'b0;
  endtask

  task automatic set_pins(logic [95:0] v);
    @(negedge clk_i);
    pin_i = v;
    repeat (2) @(negedge clk_i);
  endtask

  // model updates
  task automatic m_alias(int p, int n, logic b);
    if (impl(p)[n]) out_m[p][n] = b;
  endtask
  task automatic m_out(int p, logic [15:0] d);
    out_m[p] = ((out_m[p] & msk_m[p]) | (d & ~msk_m[p])) & impl(p);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: act=hung exp=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd2718));
    for (int p = 0; p < 6; p++) begin out_m[p] = '0; msk_m[p] = '0; end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R8 reset state
    chk("R8 pin_o reset", pin_o, '0);
    chk("R8 rdata reset", 96'(bus_rdata_o), '0);
    rd(12'h044, r); chk("R8 mask reset", 96'(r), '0);
    rd(12'h088, r); chk("R8 input reset", 96'(r), '0);

    // R3 R1: alias write with low address bits set
    wr(12'h203, 32'hFFFF_FFFF); m_alias(0, 0, 1'b1);
    chk("R1 R3 alias write PA0", pin_o, exp_pins());
    wr(alias_addr(2, 9), 32'h1); m_alias(2, 9, 1'b1);
    chk("R3 alias write PC9", pin_o, exp_pins());
    wr(alias_addr(2, 9), 32'hFFFF_FFFE); m_alias(2, 9, 1'b0);
    chk("R3 alias clear uses bit0 only", pin_o, exp_pins());

    // R4: masked pin driven through alias; R5 port write respects mask
    wr(12'h0C4, 32'h0000_00F0); msk_m[3] = 16'h00F0;
    rd(12'h0C4, r); chk("R7 mask readback", 96'(r), 96'h00F0);
    wr(alias_addr(3, 5), 32'h1); m_alias(3, 5, 1'b1);
    chk("R4 alias bypasses mask", pin_o, exp_pins());
    wr(12'h0C0, 32'h0000_FF0F); m_out(3, 16'hFF0F);
    chk("R5 masked port write", pin_o, exp_pins());
    rd(12'h0C0, r); chk("R5 output readback", 96'(r), 96'(out_m[3]));

    // R6 unimplemented pins
    wr(alias_addr(4, 14), 32'h1); wr(alias_addr(4, 15), 32'h1);
    wr(alias_addr(5, 8), 32'h1);  wr(alias_addr(5, 15), 32'h1);
    chk("R6 unimpl alias writes", pin_o, exp_pins());
    wr(12'h140, 32'hFFFF); m_out(5, 16'hFFFF);
    wr(12'h104, 32'hFFFF); msk_m[4] = 16'h3FFF;
    chk("R6 port write unimpl bits", pin_o, exp_pins());
    rd(12'h104, r); chk("R6 R7 mask unimpl bits", 96'(r), 96'h3FFF);
    set_pins('1);
    rd(alias_addr(4, 14), r); chk("R6 unimpl alias read", 96'(r), '0);
    rd(alias_addr(5, 12), r); chk("R6 unimpl alias read PF12", 96'(r), '0);
    rd(12'h148, r); chk("R6 R7 input word port5", 96'(r), 96'h00FF);

    // R2 R10: alias read returns pin, not latch
    set_pins('0);
    rd(alias_addr(0, 0), r); chk("R2 alias reads pin not latch", 96'(r), '0);
    set_pins(96'(1) << 37);
    rd(alias_addr(2, 5), r); chk("R10 pin change visible", 96'(r), 96'h1);
    @(negedge clk_i);
    chk("R9 idle rdata zero", 96'(bus_rdata_o), '0);

    // R9 unmapped
    rd(12'h180, r); chk("R9 unmapped port6", 96'(r), '0);
    rd(12'h00C, r); chk("R9 unmapped offset 0xC", 96'(r), '0);
    rd(12'h400, r); chk("R9 unmapped 0x400", 96'(r), '0);
    rd(12'h3C0, r); chk("R9 unmapped alias port7", 96'(r), '0);

    // random mix
    for (int i = 0; i < 400; i++) begin
      int op = $urandom % 6;
      int p = $urandom % 6;
      int n = $urandom % 16;
      logic [31:0] d = $urandom;
      case (op)
        0: begin wr(alias_addr(p, n), d); m_alias(p, n, d[0]);
             chk("R3 random alias write", pin_o, exp_pins()); end
        1: begin wr(12'(p * 64), d); m_out(p, d[15:0]);
             chk("R5 random port write", pin_o, exp_pins()); end
        2: begin wr(12'(p * 64 + 4), d); msk_m[p] = d[15:0] & impl(p);
             chk("R7 random mask write", pin_o, exp_pins()); end
        3: begin rd(alias_addr(p, n), r);
             chk("R2 random alias read", 96'(r), 96'(pin_i[p*16+n] & impl(p)[n])); end
        4: begin rd(12'(p * 64 + 8 * (n % 2)), r);
             chk("R5 R7 random port read", 96'(r),
                 96'((n % 2) ? (pin_i[p*16 +: 16] & impl(p)) : out_m[p])); end
        default: begin
             logic [95:0] v = {$urandom, $urandom, $urandom};
             set_pins(v); end
      endcase
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule